// File: doc/BRIEF.md
# Atomic Memory Sequencer

This block executes atomic memory instructions on behalf of a processor core. The core hands it one operation at a time: a load-reserved, a store-conditional, or a read-modify-write that combines the current memory word with a source operand. The block then owns a single-port memory interface until the operation is finished. Each operation ends with a one-cycle completion strobe. The strobe carries the value destined for the core's destination register.

The datapath is XLEN bits wide, with XLEN set to 32 or 64. On a 64-bit datapath a word form is available. It operates on the low 32 bits of the memory word, sign-extends what it reads, and writes only the low four bytes back. Reserved addresses are held in a small list ordered by age. A store-conditional looks for an exact address match in that list and, on a hit, removes that one entry.

The memory port has a request, a write enable, byte enables, an address, write data, read data and a ready. A transfer completes in a cycle where both request and ready are high, and read data is taken in that same cycle. Operation codes on `op_kind`: 0 load-reserved, 1 store-conditional, 2 swap, 3 add, 4 and, 5 or, 6 xor, 7 signed min, 8 signed max, 9 unsigned min, 10 unsigned max.

Top module: `amo_unit`

## Requirements
- R1: After reset, busy, done and mem_req are low and no address is reserved, so a store-conditional to any address fails.
- R2: A load-reserved (code 0) reads the word at op_addr, returns it on done_val, and reserves the address. A repeated load-reserved to an already reserved address adds no second entry.
- R3: A store-conditional (code 1) to a reserved address writes op_src to that address, returns 0, and removes the reservation, so an immediate repeat returns 1.
- R4: A store-conditional to an unreserved address issues no memory write and returns 1.
- R5: Every read-modify-write code (2 to 10) returns the old memory word and writes back the combination of the old word and op_src: swap writes op_src, add writes the wrapped sum, and and/or/xor write the bitwise result.
- R6: Codes 7 and 8 select the smaller and larger value as two's-complement numbers. Codes 9 and 10 compare them as unsigned numbers.
- R7: With op_word high and XLEN 64, the low 32 bits read are sign-extended before they are returned and before they are combined. op_src is sign-extended from bit 31 as well. Only the low four bytes are written (mem_be = 0x0F), so the upper half of the memory word is kept.
- R8: The list holds RSV_DEPTH addresses. A load-reserved to a new address while the list is full drops the oldest entry.
- R9: busy stays high from acceptance until after the final memory transfer. While it is high, the memory request holds its address and data until ready, and op_valid is ignored.
- R10: done is high for exactly one cycle per accepted operation, with done_val holding the result in that cycle.
- R11: An op_kind code above 10 is ignored: no memory request and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered (taken when idle) |
| op_kind | input | 4 | Operation code |
| op_word | input | 1 | 32-bit form on a 64-bit datapath |
| op_addr | input | ADDR_W | Byte address of the word |
| op_src | input | XLEN | Source operand / store data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| done_val | output | XLEN | Destination register value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | XLEN | Memory write data |
| mem_be | output | XLEN/8 | Byte enables for writes |
| mem_rdata | input | XLEN | Memory read data |
| mem_ready | input | 1 | Transfer completes this cycle |

## Verification
The hardest state to reach from the ports is a full reservation list whose oldest entry is about to be dropped. Only a history of distinct load-reserves fills the list, and the eviction itself is invisible: it shows up only as a later store-conditional failing. The stimulus issues exactly RSV_DEPTH fresh load-reserves, then one more, and probes the first and second addresses with store-conditionals. The second case is an operation offered while a read-modify-write is held up by a stalling memory. The bench stretches ready with a wait counter, so the stray request lands between the read and the write.

// File: rtl/amo_pkg.sv
package amo_pkg;

   typedef enum logic [3:0] {
      OPK_LR   = 4'd0,
      OPK_SC   = 4'd1,
      OPK_SWAP = 4'd2,
      OPK_ADD  = 4'd3,
      OPK_AND  = 4'd4,
      OPK_OR   = 4'd5,
      OPK_XOR  = 4'd6,
      OPK_MIN  = 4'd7,
      OPK_MAX  = 4'd8,
      OPK_MINU = 4'd9,
      OPK_MAXU = 4'd10
   } amo_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_FIN   = 2'd3
   } amo_state_e;

   localparam logic [3:0] OPK_LAST = 4'd10;

   function automatic logic kind_known(input logic [3:0] k);
      return k <= OPK_LAST;
   endfunction

endpackage

// File: rtl/amo_combine.sv
module amo_combine
   import amo_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [3:0]   kind,
   input  logic [W-1:0] old_val,
   input  logic [W-1:0] src_val,
   output logic [W-1:0] res
);
   logic lt_s;
   logic lt_u;

   assign lt_s = $signed(old_val) < $signed(src_val);
   assign lt_u = old_val < src_val;

   always_comb begin
      case (kind)
         OPK_SWAP: res = src_val;
         OPK_ADD:  res = old_val + src_val;
         OPK_AND:  res = old_val & src_val;
         OPK_OR:   res = old_val | src_val;
         OPK_XOR:  res = old_val ^ src_val;
         OPK_MIN:  res = lt_s ? old_val : src_val;
         OPK_MAX:  res = lt_s ? src_val : old_val;
         OPK_MINU: res = lt_u ? old_val : src_val;
         OPK_MAXU: res = lt_u ? src_val : old_val;
         default:  res = src_val;
      endcase
   end
endmodule

// File: rtl/amo_rsv_table.sv
module amo_rsv_table #(
   parameter int AW    = 16,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ins_en,
   input  logic [AW-1:0] ins_addr,
   input  logic [AW-1:0] chk_addr,
   input  logic          rm_en,
   output logic          hit
);
   // entry 0 is the newest, valid entries are kept packed toward index 0
   logic [DEPTH-1:0] vld;
   logic [AW-1:0]    adr [DEPTH];
   logic [DEPTH-1:0] m_ins;
   logic [DEPTH-1:0] m_chk;
   logic [DEPTH-1:0] gone;
   logic             dup;
   logic             do_ins;
   logic             do_rm;

   always_comb begin
      logic acc;
      acc = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         m_ins[i] = vld[i] && (adr[i] == ins_addr);
         m_chk[i] = vld[i] && (adr[i] == chk_addr);
         acc      = acc | m_chk[i];
         gone[i]  = acc;
      end
   end

   assign dup    = |m_ins;
   assign hit    = |m_chk;
   assign do_ins = ins_en && !dup;
   assign do_rm  = rm_en && hit;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic          v;
      logic [AW-1:0] a;
      logic          up_v;
      logic [AW-1:0] up_a;
      logic          dn_v;
      logic [AW-1:0] dn_a;

      if (i == DEPTH - 1) begin : g_tail
         assign up_v = 1'b0;
         assign up_a = '0;
      end else begin : g_mid
         assign up_v = vld[i+1];
         assign up_a = adr[i+1];
      end

      if (i == 0) begin : g_head
         assign dn_v = 1'b1;
         assign dn_a = ins_addr;
      end else begin : g_body
         assign dn_v = vld[i-1];
         assign dn_a = adr[i-1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v <= 1'b0;
            a <= '0;
         end else if (do_ins) begin
            v <= dn_v;
            a <= dn_a;
         end else if (do_rm && gone[i]) begin
            v <= up_v;
            a <= up_a;
         end
      end

      assign vld[i] = v;
      assign adr[i] = a;
   end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
   import amo_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int ADDR_W    = 16,
   parameter int RSV_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_kind,
   input  logic              op_word,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [XLEN-1:0]   op_src,
   output logic              busy,
   output logic              done,
   output logic [XLEN-1:0]   done_val,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [XLEN-1:0]   mem_wdata,
   output logic [XLEN/8-1:0] mem_be,
   input  logic [XLEN-1:0]   mem_rdata,
   input  logic              mem_ready
);
   localparam int              BE_W    = XLEN / 8;
   localparam logic            WORD_OK = (XLEN == 64);
   localparam logic [BE_W-1:0] LOW_BE  = BE_W'(15);

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("amo_unit: XLEN must be 32 or 64");
   end
   if (RSV_DEPTH < 1) begin : g_bad_depth
      $error("amo_unit: RSV_DEPTH must be at least 1");
   end
   if (ADDR_W < 4) begin : g_bad_aw
      $error("amo_unit: ADDR_W too small");
   end

   amo_state_e        st;
   logic [3:0]        cur_kind;
   logic              cur_word;
   logic [ADDR_W-1:0] cur_addr;
   logic [XLEN-1:0]   cur_src;
   logic [XLEN-1:0]   result;
   logic [XLEN-1:0]   wdata_q;

   logic              accept;
   logic              tbl_hit;
   logic              ins_en;
   logic              rm_en;
   logic [XLEN-1:0]   old_val;
   logic [XLEN-1:0]   src_eff;
   logic [XLEN-1:0]   comb_res;
   logic [BE_W-1:0]   be_wr;

   assign accept = (st == ST_IDLE) && op_valid && kind_known(op_kind);
   assign rm_en  = accept && (op_kind == OPK_SC);
   assign ins_en = (st == ST_READ) && mem_ready && (cur_kind == OPK_LR);

   // lane handling: word forms only exist on the wide datapath
   if (XLEN == 64) begin : g_wide
      assign old_val = cur_word ? {{(XLEN-32){mem_rdata[31]}}, mem_rdata[31:0]}
                                : mem_rdata;
      assign src_eff = cur_word ? {{(XLEN-32){cur_src[31]}}, cur_src[31:0]}
                                : cur_src;
      assign be_wr   = cur_word ? LOW_BE : '1;
   end else begin : g_narrow
      assign old_val = mem_rdata;
      assign src_eff = cur_src;
      assign be_wr   = '1;
   end

   amo_combine #(.W(XLEN)) u_comb (
      .kind    (cur_kind),
      .old_val (old_val),
      .src_val (src_eff),
      .res     (comb_res)
   );

   amo_rsv_table #(.AW(ADDR_W), .DEPTH(RSV_DEPTH)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ins_en   (ins_en),
      .ins_addr (cur_addr),
      .chk_addr (op_addr),
      .rm_en    (rm_en),
      .hit      (tbl_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cur_kind <= '0;
         cur_word <= 1'b0;
         cur_addr <= '0;
         cur_src  <= '0;
         result   <= '0;
         wdata_q  <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  cur_kind <= op_kind;
                  cur_word <= op_word & WORD_OK;
                  cur_addr <= op_addr;
                  cur_src  <= op_src;
                  if (op_kind == OPK_SC) begin
                     if (tbl_hit) begin
                        wdata_q <= op_src;
                        result  <= '0;
                        st      <= ST_WRITE;
                     end else begin
                        result  <= XLEN'(1);
                        st      <= ST_FIN;
                     end
                  end else begin
                     st <= ST_READ;
                  end
               end
            end
            ST_READ: begin
               if (mem_ready) begin
                  result <= old_val;
                  if (cur_kind == OPK_LR) begin
                     st <= ST_FIN;
                  end else begin
                     wdata_q <= comb_res;
                     st      <= ST_WRITE;
                  end
               end
            end
            ST_WRITE: begin
               if (mem_ready) st <= ST_FIN;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign done      = (st == ST_FIN);
   assign done_val  = result;
   assign mem_req   = (st == ST_READ) || (st == ST_WRITE);
   assign mem_we    = (st == ST_WRITE);
   assign mem_addr  = cur_addr;
   assign mem_wdata = wdata_q;
   assign mem_be    = (st == ST_WRITE) ? be_wr : '1;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
   parameter int XLEN   = 64,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [XLEN-1:0]   mem_wdata,
   input logic [XLEN/8-1:0] mem_be,
   input logic              cur_word
);
   localparam int              BE_W   = XLEN / 8;
   localparam logic [BE_W-1:0] LOW_BE = BE_W'(15);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req); // R10

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))); // R9

   AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy); // R9

   AST_WORD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && cur_word) |-> (mem_be == LOW_BE)); // R7
endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_be    (mem_be),
   .cur_word  (cur_word)
);

// File: tb/amo_unit_bench.sv
`timescale 1ns/1ps
module amo_unit_bench;
   localparam int XLEN   = 64;
   localparam int ADDR_W = 16;
   localparam int DEPTH  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              op_valid = 1'b0;
   logic [3:0]        op_kind = '0;
   logic              op_word = 1'b0;
   logic [ADDR_W-1:0] op_addr = '0;
   logic [XLEN-1:0]   op_src = '0;
   logic              busy, done, mem_req, mem_we, mem_ready;
   logic [XLEN-1:0]   done_val, mem_wdata, mem_rdata;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_be;

   always #10 clk = ~clk;

   amo_unit #(.XLEN(XLEN), .ADDR_W(ADDR_W), .RSV_DEPTH(DEPTH)) u_amo_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .op_word(op_word), .op_addr(op_addr), .op_src(op_src), .busy(busy),
      .done(done), .done_val(done_val), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   // memory model: 16 words of 64 bits, index from address bits 6:3
   logic [63:0] mem [16];
   logic        stall_en = 1'b0;
   int          wait_cnt = 0;
   logic        poke_en = 1'b0;
   logic [3:0]  poke_idx = '0;
   logic [63:0] poke_val = '0;
   int          n_writes = 0;

   assign mem_ready = mem_req && (wait_cnt == 0);
   assign mem_rdata = mem[mem_addr[6:3]];

   always @(posedge clk) begin
      if (poke_en) mem[poke_idx] <= poke_val;
      else if (mem_req && mem_ready && mem_we) begin
         for (int b = 0; b < 8; b++)
            if (mem_be[b]) mem[mem_addr[6:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
         n_writes <= n_writes + 1;
      end
      if (mem_req && !mem_ready) wait_cnt <= wait_cnt - 1;
      else if (mem_req && mem_ready) wait_cnt <= stall_en ? 2 : 0;
   end

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [3:0] idx, input logic [63:0] val);
      @(negedge clk);
      poke_en = 1'b1; poke_idx = idx; poke_val = val;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   task automatic start_op(input logic [3:0] k, input logic w, input logic [3:0] idx,
                           input logic [63:0] src);
      @(negedge clk);
      op_valid = 1'b1; op_kind = k; op_word = w;
      op_addr = ADDR_W'({idx, 3'b000}); op_src = src;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic wait_done(output logic [63:0] v);
      bit seen = 0;
      v = 'x;
      for (int c = 0; c < 100; c++) begin
         if (done) begin v = done_val; seen = 1; break; end
         @(negedge clk);
      end
      chk("R10 done seen", 64'(seen), 64'd1);
      @(negedge clk);
      chk("R10 done single cycle", 64'(done), 64'd0);
   endtask

   task automatic run(input logic [3:0] k, input logic w, input logic [3:0] idx,
                      input logic [63:0] src, output logic [63:0] v);
      start_op(k, w, idx, src);
      wait_done(v);
   endtask

   typedef struct packed {
      logic [1:0]  cat;
      logic [3:0]  kind;
      logic        word;
      logic [3:0]  idx;
      logic [63:0] src;
      logic [63:0] pre;
      logic [63:0] ret;
      logic [63:0] post;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 4'd2, 1'b0, 4'd0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD},
      '{2'd0, 4'd3, 1'b0, 4'd1, 64'd7, 64'd5, 64'd5, 64'd12},
      '{2'd0, 4'd3, 1'b0, 4'd2, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1},
      '{2'd0, 4'd4, 1'b0, 4'd3, 64'hFF00, 64'hF0F0, 64'hF0F0, 64'hF000},
      '{2'd0, 4'd5, 1'b0, 4'd4, 64'hFF00, 64'hF0F0, 64'hF0F0, 64'hFFF0},
      '{2'd0, 4'd6, 1'b0, 4'd5, 64'hFF00, 64'hF0F0, 64'hF0F0, 64'h0FF0},
      '{2'd1, 4'd7, 1'b0, 4'd6, 64'd4, 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFD},
      '{2'd1, 4'd8, 1'b0, 4'd7, 64'd4, 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFD, 64'd4},
      '{2'd1, 4'd9, 1'b0, 4'd8, 64'd4, 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFD, 64'd4},
      '{2'd1, 4'd10, 1'b0, 4'd9, 64'd4, 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFD},
      '{2'd1, 4'd7, 1'b0, 4'd14, 64'hFFFF_FFFF_FFFF_FF00, 64'h10, 64'h10, 64'hFFFF_FFFF_FFFF_FF00},
      '{2'd1, 4'd8, 1'b0, 4'd15, 64'hFFFF_FFFF_FFFF_FF00, 64'h10, 64'h10, 64'h10},
      '{2'd2, 4'd3, 1'b1, 4'd10, 64'd1, 64'h1234_5678_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, 64'h1234_5678_8000_0000},
      '{2'd2, 4'd7, 1'b1, 4'd11, 64'h0000_0000_FFFF_FFF0, 64'hAAAA_AAAA_0000_0003, 64'd3, 64'hAAAA_AAAA_FFFF_FFF0},
      '{2'd2, 4'd10, 1'b1, 4'd12, 64'h0000_0000_8000_0000, 64'h5555_5555_0000_0010, 64'h10, 64'h5555_5555_8000_0000},
      '{2'd2, 4'd2, 1'b1, 4'd13, 64'hFFFF_FFFF_0000_0042, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_89AB_CDEF, 64'h0123_4567_0000_0042}
   };

   function automatic string cat_tag(input logic [1:0] c);
      case (c)
         2'd0:    return "R5";
         2'd1:    return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [63:0] v;
      int          w0;
      bit          extra;

      for (int i = 0; i < 16; i++) mem[i] = 64'h0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy after reset", 64'(busy), 64'd0);
      chk("R1 done after reset", 64'(done), 64'd0);
      chk("R1 mem_req after reset", 64'(mem_req), 64'd0);
      rst_n = 1'b1;

      // R1 / R4: empty list, store-conditional fails without a write
      poke(4'd15, 64'h5A5A);
      w0 = n_writes;
      run(4'd1, 1'b0, 4'd15, 64'h1234, v);
      chk("R1 sc after reset returns", v, 64'd1);
      chk("R4 sc miss no write", 64'(n_writes - w0), 64'd0);
      chk("R4 sc miss memory kept", mem[15], 64'h5A5A);

      // R5 R6 R7: vector table
      for (int i = 0; i < NV; i++) begin
         stall_en = i[0];
         poke(VEC[i].idx, VEC[i].pre);
         run(VEC[i].kind, VEC[i].word, VEC[i].idx, VEC[i].src, v);
         chk({cat_tag(VEC[i].cat), " returned old value"}, v, VEC[i].ret);
         chk({cat_tag(VEC[i].cat), " written value"}, mem[VEC[i].idx], VEC[i].post);
      end
      stall_en = 1'b0;

      // R2: load-reserved returns word; duplicate adds no entry; R3 consume
      poke(4'd5, 64'hCAFE_0000_BEEF_0001);
      run(4'd0, 1'b0, 4'd5, 64'd0, v);
      chk("R2 lr returns word", v, 64'hCAFE_0000_BEEF_0001);
      run(4'd0, 1'b0, 4'd5, 64'd0, v);
      run(4'd1, 1'b0, 4'd5, 64'h77, v);
      chk("R3 sc hit returns 0", v, 64'd0);
      chk("R3 sc hit writes data", mem[5], 64'h77);
      w0 = n_writes;
      run(4'd1, 1'b0, 4'd5, 64'h88, v);
      chk("R2 duplicate lr left no second entry", v, 64'd1);
      chk("R3 second sc no write", 64'(n_writes - w0), 64'd0);

      // R8: fill list, one more evicts the oldest
      for (int i = 8; i < 8 + DEPTH; i++) run(4'd0, 1'b0, 4'(i), 64'd0, v);
      run(4'd0, 1'b0, 4'd12, 64'd0, v);
      poke(4'd8, 64'h1111);
      run(4'd1, 1'b0, 4'd8, 64'h2222, v);
      chk("R8 oldest evicted sc fails", v, 64'd1);
      chk("R8 oldest evicted memory kept", mem[8], 64'h1111);
      run(4'd1, 1'b0, 4'd9, 64'h3333, v);
      chk("R8 second oldest still reserved", v, 64'd0);
      chk("R8 second oldest written", mem[9], 64'h3333);

      // R7: word load-reserved / store-conditional
      poke(4'd13, 64'h1122_3344_8000_0001);
      run(4'd0, 1'b1, 4'd13, 64'd0, v);
      chk("R7 lr word sign extends", v, 64'hFFFF_FFFF_8000_0001);
      run(4'd1, 1'b1, 4'd13, 64'hAAAA_AAAA_0000_0007, v);
      chk("R7 sc word returns 0", v, 64'd0);
      chk("R7 sc word keeps upper half", mem[13], 64'h1122_3344_0000_0007);

      // R9: offer while busy is ignored
      stall_en = 1'b1;
      poke(4'd3, 64'd10);
      poke(4'd4, 64'h4444);
      start_op(4'd3, 1'b0, 4'd3, 64'd1);
      chk("R9 busy after accept", 64'(busy), 64'd1);
      op_valid = 1'b1; op_kind = 4'd2; op_word = 1'b0;
      op_addr = ADDR_W'({4'd4, 3'b000}); op_src = 64'd99;
      @(negedge clk);
      op_valid = 1'b0;
      wait_done(v);
      chk("R9 amo under stall returns old", v, 64'd10);
      chk("R9 amo under stall writes sum", mem[3], 64'd11);
      extra = 0;
      for (int c = 0; c < 12; c++) begin
         if (done || mem_req) extra = 1;
         @(negedge clk);
      end
      chk("R9 offer during busy not executed", 64'(extra), 64'd0);
      chk("R9 other address untouched", mem[4], 64'h4444);
      stall_en = 1'b0;

      // R11: undefined code ignored
      start_op(4'd15, 1'b0, 4'd4, 64'd5);
      extra = 0;
      for (int c = 0; c < 10; c++) begin
         if (done || mem_req || busy) extra = 1;
         @(negedge clk);
      end
      chk("R11 undefined code no activity", 64'(extra), 64'd0);
      chk("R11 undefined code memory kept", mem[4], 64'h4444);

      summary();
   end
endmodule